// File: doc/BRIEF.md
# Indexed Configuration RAM with Lazy Checksum

This block is a 64-byte configuration store that software reaches through two byte-wide ports sharing one request strobe. A write to the index port chooses a byte. Reads and writes on the data port then act on that byte. Every byte comes out of reset with a defined value. A 16-bit checksum over a fixed window of configuration bytes is kept in two reserved bytes of the same array.

The checksum is built lazily. The first data-port access after reset, or after a recompute request, is held while a sequential engine walks the window one byte per clock. The engine writes the sum back into the array and then serves the held access. During that time `busy` is high, and requests that arrive are dropped. Index-port accesses are always served at once.

The controller has four states. `S_IDLE` serves requests directly. Its transition *start-sum* leads to `S_SUM` when a data access finds the checksum stale. `S_SUM` adds one byte per cycle and takes the *window-done* transition to `S_STORE` after the last window byte. `S_STORE` writes both checksum bytes and always moves on (*stored*) to `S_SERVE`. `S_SERVE` performs the held access and returns (*served*) to `S_IDLE`.

Top module: `cfg_ram_csum`

## Requirements
- R1: An index write (req=1, req_data=0, req_wr=1) stores wdata[6:0]. An index read returns {1'b0, stored index} on rdata, with rd_valid high, in the cycle after the request edge.
- R2: Data accesses address the array with only index bits [5:0]. Index bit 6 is kept but ignored, so indexes 0x3F and 0x7F reach the same byte.
- R3: After reset, byte 0x0A=0x26, 0x0B=0x02, 0x0C=0x50, 0x0D=0x80 and 0x32=0x19. Every other byte holds (address XOR 0x5A). The index, rdata, rd_valid and busy are all 0.
- R4: The checksum is the 16-bit sum of bytes 0x10 to 0x2C inclusive. Its high byte is stored at 0x2E and its low byte at 0x2F.
- R5: A data access that finds the checksum stale raises busy for exactly 31 cycles: 29 sum cycles, one store and one serve. The held access completes only after the store, and a held read shows rd_valid in the first cycle busy is low.
- R6: Index-port accesses never start the checksum engine.
- R7: Data writes made after the checksum is stored do not change the stored checksum bytes.
- R8: A pulse on recalc marks the checksum stale, so the next data access recomputes it over the current bytes.
- R9: Requests that arrive while busy is high are dropped and change no state.
- R10: With a valid checksum, a data write stores wdata at the selected byte, and a data read returns it in the cycle after the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle access request |
| req_data | input | 1 | 1 selects the data port, 0 selects the index port |
| req_wr | input | 1 | 1 for write, 0 for read |
| wdata | input | 8 | Write byte |
| recalc | input | 1 | Marks the checksum stale |
| rdata | output | 8 | Last read result |
| rd_valid | output | 1 | One-cycle pulse when rdata is updated by a read |
| busy | output | 1 | Checksum engine active; requests are dropped |

## Verification
The bench uses the default parameters: a 6-bit array address, a 7-bit index and the window 0x10 to 0x2C. That puts the 31-cycle busy window, the bit-6 alias between 0x3F and 0x7F, and a checksum low byte that moves when one window byte is edited all within reach of short directed sequences. A request injected mid-computation exercises the drop path. A window edit before and after a recompute pulse separates the stale and fresh checksum values.

// File: rtl/cfg_ram_pkg.sv
package cfg_ram_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SUM   = 2'd1,
        S_STORE = 2'd2,
        S_SERVE = 2'd3
    } ctrl_state_e;

    // Power-on content of one byte of the store.
    function automatic logic [7:0] reset_byte(input logic [7:0] addr);
        logic [7:0] val;
        case (addr)
            8'h0A:   val = 8'h26;
            8'h0B:   val = 8'h02;
            8'h0C:   val = 8'h50;
            8'h0D:   val = 8'h80;
            8'h32:   val = 8'h19;
            default: val = addr ^ 8'h5A;
        endcase
        return val;
    endfunction

endpackage

// File: rtl/cfg_ram_array.sv
module cfg_ram_array #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 6,
    parameter int SUM_W    = 16,
    parameter int CS_HI    = 46,
    parameter int CS_LO    = 47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cs_we,
    input  logic [SUM_W-1:0]  cs_val
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[gi] <= DATA_W'(cfg_ram_pkg::reset_byte(8'(gi)));
            end else if (cs_we && (gi == CS_HI)) begin
                mem[gi] <= cs_val[SUM_W-1 -: DATA_W];
            end else if (cs_we && (gi == CS_LO)) begin
                mem[gi] <= cs_val[DATA_W-1:0];
            end else if (wr_en && (wr_addr == ADDR_W'(gi))) begin
                mem[gi] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cfg_csum_accum.sv
module cfg_csum_accum #(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [DATA_W-1:0] byte_in,
    output logic [SUM_W-1:0]  sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clr) begin
            sum <= '0;
        end else if (add) begin
            sum <= sum + SUM_W'(byte_in);
        end
    end
endmodule

// File: rtl/cfg_ram_ctrl.sv
module cfg_ram_ctrl
    import cfg_ram_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 6,
    parameter int IDX_W    = 7,
    parameter int CS_FIRST = 16,
    parameter int CS_LAST  = 44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_data,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              recalc,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              cs_we,
    output logic              acc_clr,
    output logic              acc_add,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              busy
);
    ctrl_state_e       state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] scan_q;
    logic              pend_wr_q;
    logic [DATA_W-1:0] pend_wdata_q;
    logic              csum_ok_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    logic accept, need_cs, direct_rd, scan_end;

    assign accept    = (state_q == S_IDLE) && req;
    assign need_cs   = accept && req_data && !csum_ok_q;
    assign direct_rd = accept && !req_wr && (!req_data || csum_ok_q);
    assign scan_end  = (scan_q == ADDR_W'(CS_LAST));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (need_cs) state_d = S_SUM;       // start-sum
            S_SUM:   if (scan_end) state_d = S_STORE;    // window-done
            S_STORE: state_d = S_SERVE;                  // stored
            S_SERVE: state_d = S_IDLE;                   // served
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        mem_raddr = (state_q == S_SUM) ? scan_q : idx_q[ADDR_W-1:0];
        mem_waddr = idx_q[ADDR_W-1:0];
        mem_wdata = (state_q == S_SERVE) ? pend_wdata_q : wdata;
        mem_we    = (accept && req_data && req_wr && csum_ok_q) ||
                    ((state_q == S_SERVE) && pend_wr_q);
        cs_we     = (state_q == S_STORE);
        acc_clr   = need_cs;
        acc_add   = (state_q == S_SUM);
        busy      = (state_q != S_IDLE);
        rdata     = rdata_q;
        rd_valid  = rvalid_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q        <= '0;
            scan_q       <= '0;
            pend_wr_q    <= 1'b0;
            pend_wdata_q <= '0;
            csum_ok_q    <= 1'b0;
            rdata_q      <= '0;
            rvalid_q     <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            if (accept && !req_data && req_wr) begin
                idx_q <= wdata[IDX_W-1:0];
            end
            if (need_cs) begin
                scan_q       <= ADDR_W'(CS_FIRST);
                pend_wr_q    <= req_wr;
                pend_wdata_q <= wdata;
            end else if (state_q == S_SUM) begin
                scan_q <= scan_q + 1'b1;
            end
            if (recalc) begin
                csum_ok_q <= 1'b0;
            end else if (state_q == S_STORE) begin
                csum_ok_q <= 1'b1;
            end
            if (direct_rd) begin
                rvalid_q <= 1'b1;
                rdata_q  <= req_data ? mem_rdata
                                     : {{(DATA_W-IDX_W){1'b0}}, idx_q};
            end else if ((state_q == S_SERVE) && !pend_wr_q) begin
                rvalid_q <= 1'b1;
                rdata_q  <= mem_rdata;
            end
        end
    end
endmodule

// File: rtl/cfg_ram_csum.sv
module cfg_ram_csum #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 6,
    parameter int IDX_W    = 7,
    parameter int SUM_W    = 16,
    parameter int CS_FIRST = 16,
    parameter int CS_LAST  = 44,
    parameter int CS_HI    = 46,
    parameter int CS_LO    = 47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_data,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              recalc,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              busy
);
    localparam int BUSY_LEN = CS_LAST - CS_FIRST + 3;

    logic [ADDR_W-1:0] mem_raddr, mem_waddr;
    logic [DATA_W-1:0] mem_rdata, mem_wdata;
    logic              mem_we, cs_we, acc_clr, acc_add;
    logic [SUM_W-1:0]  acc_sum;

    cfg_ram_array #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SUM_W(SUM_W),
        .CS_HI(CS_HI), .CS_LO(CS_LO)
    ) array_i (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(mem_raddr), .rd_data(mem_rdata),
        .wr_en(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata),
        .cs_we(cs_we), .cs_val(acc_sum)
    );

    cfg_csum_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) accum_i (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add),
        .byte_in(mem_rdata), .sum(acc_sum)
    );

    cfg_ram_ctrl #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .CS_FIRST(CS_FIRST), .CS_LAST(CS_LAST)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_data(req_data),
        .req_wr(req_wr), .wdata(wdata), .recalc(recalc),
        .mem_rdata(mem_rdata), .mem_raddr(mem_raddr), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .cs_we(cs_we),
        .acc_clr(acc_clr), .acc_add(acc_add), .rdata(rdata),
        .rd_valid(rd_valid), .busy(busy)
    );
endmodule

// File: rtl/cfg_ram_csum_chk.sv
module cfg_ram_csum_chk #(
    parameter int BUSY_LEN = 31
) (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic req_data,
    input logic busy,
    input logic rd_valid
);
    logic [15:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 16'd1;
        else           busy_cnt <= '0;
    end

    // R5: a busy episode lasts exactly the sum, store and serve cycles
    a_r5_busy_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == 16'(BUSY_LEN)));

    // R5: busy never outlasts the episode length
    a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < 16'(BUSY_LEN)));

    // R5: read results are delivered only when the engine is idle
    a_r5_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);

    // R6: the engine starts only from a data-port request
    a_r6_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req && req_data));
endmodule

bind cfg_ram_csum cfg_ram_csum_chk #(.BUSY_LEN(CS_LAST - CS_FIRST + 3)) chk_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_data(req_data),
    .busy(busy), .rd_valid(rd_valid)
);

// File: tb/cfg_ram_csum_tb_top.sv
module cfg_ram_csum_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, req_data = 1'b0, req_wr = 1'b0, recalc = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rd_valid, busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfg_ram_csum dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_data(req_data),
        .req_wr(req_wr), .wdata(wdata), .recalc(recalc),
        .rdata(rdata), .rd_valid(rd_valid), .busy(busy)
    );

    // op: bit1 = data port, bit0 = write; {op, value, expected}
    localparam int NV = 20;
    localparam logic [17:0] VEC [NV] = '{
        {2'd1, 8'h0A, 8'h00}, {2'd2, 8'h00, 8'h26},
        {2'd1, 8'h8B, 8'h00}, {2'd0, 8'h00, 8'h0B},
        {2'd2, 8'h00, 8'h02}, {2'd1, 8'h4C, 8'h00},
        {2'd2, 8'h00, 8'h50}, {2'd0, 8'h00, 8'h4C},
        {2'd1, 8'h0D, 8'h00}, {2'd2, 8'h00, 8'h80},
        {2'd1, 8'h32, 8'h00}, {2'd2, 8'h00, 8'h19},
        {2'd3, 8'hA7, 8'h00}, {2'd2, 8'h00, 8'hA7},
        {2'd1, 8'h3F, 8'h00}, {2'd3, 8'hC3, 8'h00},
        {2'd1, 8'h7F, 8'h00}, {2'd2, 8'h00, 8'hC3},
        {2'd1, 8'h05, 8'h00}, {2'd2, 8'h00, 8'h5F}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input bit d, input bit w, input logic [7:0] v,
                          output int bcyc);
        @(negedge clk);
        req = 1'b1; req_data = d; req_wr = w; wdata = v;
        @(negedge clk);
        req = 1'b0;
        bcyc = 0;
        while (busy && bcyc < 1000) begin
            bcyc++;
            @(negedge clk);
        end
    endtask

    function automatic int window_sum();
        int s = 0;
        for (int a = 16; a <= 44; a++) s += (a ^ 8'h5A) & 8'hFF;
        return s & 16'hFFFF;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int bc;
        int sum0, sum1;
        sum0 = window_sum();
        sum1 = (sum0 - 8'h4A) & 16'hFFFF;

        repeat (3) @(negedge clk);
        check("R3 reset rdata", rdata, 0);
        check("R3 reset rd_valid", rd_valid, 0);
        check("R3 reset busy", busy, 0);
        rst_n = 1'b1;

        access(1'b0, 1'b1, 8'h2E, bc);
        check("R6 index write no engine", bc, 0);
        access(1'b0, 1'b0, 8'h00, bc);
        check("R6 index read no engine", bc, 0);
        check("R1 index read value", rdata, 8'h2E);
        check("R1 index read rd_valid", rd_valid, 1);

        access(1'b1, 1'b0, 8'h00, bc);
        check("R5 first access busy cycles", bc, 31);
        check("R5 held read rd_valid", rd_valid, 1);
        check("R4 checksum high byte", rdata, (sum0 >> 8) & 8'hFF);

        access(1'b0, 1'b1, 8'h2F, bc);
        access(1'b1, 1'b0, 8'h00, bc);
        check("R10 direct read no busy", bc, 0);
        check("R4 checksum low byte", rdata, sum0 & 8'hFF);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            op = VEC[i][17:16];
            access(op[1], op[0], VEC[i][15:8], bc);
            check($sformatf("R6/R10 vector %0d busy", i), bc, 0);
            if (!op[0]) begin
                check($sformatf("R1/R2/R3/R10 vector %0d data", i),
                      rdata, VEC[i][7:0]);
                check($sformatf("R1/R10 vector %0d rd_valid", i), rd_valid, 1);
            end
        end

        // R7: edit a window byte, stored checksum stays
        access(1'b0, 1'b1, 8'h10, bc);
        access(1'b1, 1'b1, 8'h00, bc);
        access(1'b0, 1'b1, 8'h2F, bc);
        access(1'b1, 1'b0, 8'h00, bc);
        check("R7 no auto recompute busy", bc, 0);
        check("R7 stale low byte kept", rdata, sum0 & 8'hFF);

        // R8: recompute request, with a dropped request mid-run (R9)
        @(negedge clk);
        recalc = 1'b1;
        @(negedge clk);
        recalc = 1'b0;
        req = 1'b1; req_data = 1'b1; req_wr = 1'b0;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        check("R9 busy during recompute", busy, 1);
        req = 1'b1; req_data = 1'b0; req_wr = 1'b1; wdata = 8'h01;
        @(negedge clk);
        req = 1'b0;
        bc = 0;
        while (busy && bc < 1000) begin
            bc++;
            @(negedge clk);
        end
        check("R8 recomputed low byte", rdata, sum1 & 8'hFF);
        access(1'b0, 1'b0, 8'h00, bc);
        check("R9 dropped index write", rdata, 8'h2F);
        access(1'b0, 1'b1, 8'h2E, bc);
        access(1'b1, 1'b0, 8'h00, bc);
        check("R4/R8 recomputed high byte", rdata, (sum1 >> 8) & 8'hFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule